// File: doc/BRIEF.md
# Signed Fixed-Point Rounding Divider

This block divides one signed two's-complement fixed-point number by another of the same format and returns a quotient in that format. With the default parameters a value has five integer bits (the sign among them) and four fractional bits, covering -16.0 up to +15.9375 in steps of 0.0625. Both operands are converted to magnitudes, which are divided by an unsigned restoring shift-subtract loop at one quotient bit per clock. The loop produces one guard bit below the output LSB, and the final remainder gives a sticky indication. The magnitude is then rounded, either to nearest with ties to even or to nearest with ties away from zero, and negated when the operand signs differ. Rounding is therefore symmetric about zero, and the result does not depend on which operand carries the minus sign.

A caller presents both operands and the rounding select together with a one-cycle `start` while the block is idle. `busy` stays high while the loop runs. A one-cycle `done` then marks a new quotient and new flags. These outputs hold their values until the next `done`. The controller has three states. `ST_IDLE` waits for `start` and moves to `ST_SHIFT`. `ST_SHIFT` develops one quotient bit per cycle and moves to `ST_ROUND` after the last bit. `ST_ROUND` rounds, saturates or zeroes the result, pulses `done`, and returns to `ST_IDLE`.

Top module: `fxdiv_round_div`

## Requirements
- R1: A `start` sampled high in idle makes `done` a one-cycle pulse on the 11th rising edge after that edge (integer + fractional + guard bits + 1). `busy` is high from the edge after `start` until `done`, and low while `done` is high.
- R2: A `start` that arrives while `busy` is high is ignored. The operation in progress completes with its own operands.
- R3: With `round_even`=1, the quotient is x/y rounded to the nearest multiple of 2^-4. If the guard bit is 1 and the remainder is zero, that is an exact tie, and the magnitude goes to the even LSB (13/7 gives 0x01E = 1.875; 0.0625/2 gives 0; 0.1875/2 gives 0x002).
- R4: With `round_even`=0, the magnitude is incremented whenever the guard bit is 1, so ties go away from zero (0.0625/2 gives 0x001; -0.0625/2 gives 0x1FF).
- R5: The result magnitude depends only on the operand magnitudes. The result is negative exactly when the operand signs differ and the result is nonzero (1/-1 gives 0x1F0, 3/-2 gives 0x1E8, -3/-2 gives 0x018, 7.5/-2.5 gives 0x1D0, 1.375/0.125 gives 0x0B0).
- R6: A zero divisor gives `div_zero`=1, quotient 0 and `overflow`=0, with the same latency as R1.
- R7: If the rounded magnitude exceeds 255 LSBs for a positive result, or 256 LSBs for a negative one, `overflow`=1 and the quotient saturates to 0x0FF or 0x100 respectively. -16/1 gives 0x100 without overflow, and -16/-1 overflows.
- R8: After reset `busy`, `done`, quotient, `div_zero` and `overflow` are all 0. Quotient and flags change only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (accepted only when idle) |
| round_even | input | 1 | 1: ties to even, 0: ties away from zero |
| dividend | input | 9 | Signed Q5.4 dividend |
| divisor | input | 9 | Signed Q5.4 divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results updated |
| quotient | output | 9 | Signed Q5.4 rounded quotient |
| div_zero | output | 1 | Last division had a zero divisor |
| overflow | output | 1 | Last quotient saturated |

## Verification
The situation hardest to reach from the ports is an exact tie: the guard bit is 1 and the remainder is exactly zero. Uniform random operands rarely produce one, and the decision between ties-to-even and ties-away must be exercised for odd and even truncated LSBs and for both result signs. The stimulus therefore uses directed quotients of small odd multiples of 0.0625 by 2.0 in both rounding modes and with both operand signs negated. A fixed-seed random run covers the general case, and extreme operands (most negative dividend, smallest divisors) drive the pre-loop overflow path.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ROUND = 2'd2
    } div_state_e;
endpackage

// File: rtl/fxdiv_magnitude.sv
module fxdiv_magnitude #(
    parameter int W = 9
) (
    input  logic [W-1:0] value,
    output logic [W-1:0] mag,
    output logic         neg
);
    // Magnitude of the most negative code is 2^(W-1), which fits as unsigned.
    always_comb begin
        neg = value[W-1];
        mag = neg ? (~value + 1'b1) : value;
    end
endmodule

// File: rtl/fxdiv_step.sv
module fxdiv_step #(
    parameter int W = 9
) (
    input  logic [W-1:0] rem_in,
    input  logic         bit_in,
    input  logic [W-1:0] den,
    output logic [W-1:0] rem_out,
    output logic         qbit
);
    logic [W:0] trial;
    always_comb begin
        trial   = {rem_in, bit_in};
        qbit    = (trial >= {1'b0, den});
        rem_out = qbit ? (trial[W-1:0] - den) : trial[W-1:0];
    end
endmodule

// File: rtl/fxdiv_rounder.sv
module fxdiv_rounder #(
    parameter int W  = 9,
    parameter int QB = W + 1
) (
    input  logic [QB-1:0] qraw,
    input  logic          sticky,
    input  logic          round_even,
    input  logic          neg,
    input  logic          pre_ovf,
    output logic [W-1:0]  result,
    output logic          ovf
);
    localparam logic [W:0]   LIM_POS = (W+1)'((1 << (W-1)) - 1);
    localparam logic [W:0]   LIM_NEG = (W+1)'(1 << (W-1));
    localparam logic [W-1:0] SAT_POS = W'((1 << (W-1)) - 1);
    localparam logic [W-1:0] SAT_NEG = W'(1 << (W-1));

    logic [W-1:0] trunc;
    logic         guard;
    logic         inc;
    logic [W:0]   mag;

    always_comb begin
        trunc = qraw[QB-1:1];
        guard = qraw[0];
        if (round_even)
            inc = guard & (sticky | trunc[0]);
        else
            inc = guard;
        mag = {1'b0, trunc} + {{W{1'b0}}, inc};
        ovf = pre_ovf | (neg ? (mag > LIM_NEG) : (mag > LIM_POS));
        if (ovf)
            result = neg ? SAT_NEG : SAT_POS;
        else
            result = neg ? (~mag[W-1:0] + 1'b1) : mag[W-1:0];
    end
endmodule

// File: rtl/fxdiv_round_div.sv
module fxdiv_round_div
    import fxdiv_pkg::*;
#(
    parameter int INT_W  = 5,
    parameter int FRAC_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      round_even,
    input  logic [INT_W+FRAC_W-1:0]   dividend,
    input  logic [INT_W+FRAC_W-1:0]   divisor,
    output logic                      busy,
    output logic                      done,
    output logic [INT_W+FRAC_W-1:0]   quotient,
    output logic                      div_zero,
    output logic                      overflow
);
    localparam int W  = INT_W + FRAC_W;
    localparam int G  = FRAC_W + 1;
    localparam int QB = W + 1;
    localparam int CW = $clog2(QB + 1);
    localparam logic [CW-1:0] LAST = CW'(QB - 1);

    div_state_e state_q, state_d;

    logic [W-1:0]  mag_x, mag_y;
    logic          neg_x, neg_y;
    logic [W-1:0]  den_q, rem_q, rem_nx;
    logic [QB-1:0] num_q, quo_q;
    logic [CW-1:0] cnt_q;
    logic          neg_q, zero_q, povf_q, re_q, qbit;
    logic [W-1:0]  rnd_res;
    logic          rnd_ovf;
    logic [W-1:0]  quot_q;
    logic          done_q, dz_q, ovf_q;

    fxdiv_magnitude #(.W(W)) u_mag_x (.value(dividend), .mag(mag_x), .neg(neg_x));
    fxdiv_magnitude #(.W(W)) u_mag_y (.value(divisor),  .mag(mag_y), .neg(neg_y));

    fxdiv_step #(.W(W)) u_step (
        .rem_in (rem_q),
        .bit_in (num_q[QB-1]),
        .den    (den_q),
        .rem_out(rem_nx),
        .qbit   (qbit)
    );

    fxdiv_rounder #(.W(W), .QB(QB)) u_round (
        .qraw      (quo_q),
        .sticky    (rem_q != '0),
        .round_even(re_q),
        .neg       (neg_q),
        .pre_ovf   (povf_q),
        .result    (rnd_res),
        .ovf       (rnd_ovf)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)          state_d = ST_SHIFT;
            ST_SHIFT: if (cnt_q == LAST)  state_d = ST_ROUND;
            ST_ROUND:                     state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            den_q  <= '0;
            rem_q  <= '0;
            num_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            neg_q  <= 1'b0;
            zero_q <= 1'b0;
            povf_q <= 1'b0;
            re_q   <= 1'b0;
            quot_q <= '0;
            done_q <= 1'b0;
            dz_q   <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        den_q  <= mag_y;
                        rem_q  <= mag_x >> INT_W;
                        num_q  <= {mag_x[INT_W-1:0], {G{1'b0}}};
                        quo_q  <= '0;
                        cnt_q  <= '0;
                        neg_q  <= neg_x ^ neg_y;
                        zero_q <= (mag_y == '0);
                        povf_q <= ((mag_x >> INT_W) >= mag_y);
                        re_q   <= round_even;
                    end
                end
                ST_SHIFT: begin
                    rem_q <= rem_nx;
                    quo_q <= {quo_q[QB-2:0], qbit};
                    num_q <= {num_q[QB-2:0], 1'b0};
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_ROUND: begin
                    done_q <= 1'b1;
                    dz_q   <= zero_q;
                    ovf_q  <= !zero_q && rnd_ovf;
                    quot_q <= zero_q ? '0 : rnd_res;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign quotient = quot_q;
    assign div_zero = dz_q;
    assign overflow = ovf_q;
endmodule

// File: rtl/fxdiv_checker.sv
module fxdiv_checker #(
    parameter int INT_W  = 5,
    parameter int FRAC_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic                    sign_x,
    input logic                    sign_y,
    input logic [INT_W+FRAC_W-1:0] quotient,
    input logic                    div_zero,
    input logic                    overflow
);
    localparam int W  = INT_W + FRAC_W;
    localparam int QB = W + 1;
    localparam logic [W-1:0] SAT_POS = W'((1 << (W-1)) - 1);
    localparam logic [W-1:0] SAT_NEG = W'(1 << (W-1));

    logic       act_q, sgn_q;
    logic [7:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            lat_q <= '0;
            sgn_q <= 1'b0;
        end else if (start && !busy) begin
            act_q <= 1'b1;
            lat_q <= '0;
            sgn_q <= sign_x ^ sign_y;
        end else if (done) begin
            act_q <= 1'b0;
        end else if (act_q) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    p_done_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (act_q && lat_q == 8'(QB + 1)));
    p_idle_at_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_busy_running_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !done) |-> busy);
    p_sign_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && quotient != '0) |-> (quotient[W-1] == sgn_q));
    p_zero_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == '0 && !overflow));
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (quotient == SAT_POS || quotient == SAT_NEG));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(div_zero) && $stable(overflow)));
endmodule

bind fxdiv_round_div fxdiv_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .sign_x  (dividend[INT_W+FRAC_W-1]),
    .sign_y  (divisor[INT_W+FRAC_W-1]),
    .quotient(quotient),
    .div_zero(div_zero),
    .overflow(overflow)
);

// File: tb/tb_fxdiv_round_div.sv
`timescale 1ns/1ps
module tb_fxdiv_round_div;
    localparam int IW = 5;
    localparam int FW = 4;
    localparam int W  = IW + FW;
    localparam int G  = FW + 1;
    localparam int LAT = W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         round_even = 1'b1;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero, overflow;
    logic [W-1:0] quotient;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    fxdiv_round_div #(.INT_W(IW), .FRAC_W(FW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .round_even(round_even),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .div_zero(div_zero), .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    task automatic summary_and_exit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            summary_and_exit();
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Reference from the requirements: exact integer division of magnitudes
    function automatic void model(input logic [W-1:0] x, input logic [W-1:0] y, input logic re,
                                  output logic [W-1:0] q, output logic dz, output logic ov);
        int a, b, qq, r, t, g, m, inc;
        logic neg;
        a = $signed(x); b = $signed(y);
        neg = (a < 0) != (b < 0);
        if (a < 0) a = -a;
        if (b < 0) b = -b;
        dz = 0; ov = 0; q = '0;
        if (b == 0) begin dz = 1; return; end
        qq = (a << G) / b;
        r  = (a << G) % b;
        t = qq >> 1; g = qq & 1;
        inc = re ? (g & ((r != 0) | (t & 1))) : g;
        m = t + inc;
        if (neg && m > (1 << (W-1))) begin ov = 1; q = W'(1 << (W-1)); end
        else if (!neg && m > (1 << (W-1)) - 1) begin ov = 1; q = W'((1 << (W-1)) - 1); end
        else q = neg ? W'(-m) : W'(m);
    endfunction

    task automatic run_div(input logic [W-1:0] x, input logic [W-1:0] y, input logic re,
                           input string req, input logic poke_busy);
        logic [W-1:0] eq, held;
        logic edz, eov;
        int n;
        model(x, y, re, eq, edz, eov);
        @(negedge clk);
        dividend = x; divisor = y; round_even = re; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n++;
            start = 1'b0;
            if (n == 1) check(busy == 1'b1, "R1 busy", int'(busy), 1);
            if (done) break;
            if (poke_busy && n == 3) begin
                start = 1'b1; dividend = ~x; divisor = y ^ 9'h055; round_even = ~re;
            end
        end
        check(n == LAT, "R1 latency", n, LAT);
        check(busy == 1'b0, "R1 idle at done", int'(busy), 0);
        check(quotient == eq, poke_busy ? "R2 quotient" : req, int'(quotient), int'(eq));
        check(div_zero == edz, "R6 div_zero", int'(div_zero), int'(edz));
        check(overflow == eov, "R7 overflow", int'(overflow), int'(eov));
        held = quotient;
        @(negedge clk);
        check(done == 1'b0 && quotient == held, "R8 hold", int'(quotient), int'(held));
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0, "R8 reset ctrl", int'({busy, done}), 0);
        check(quotient == 0 && div_zero == 0 && overflow == 0, "R8 reset data",
              int'({quotient, div_zero, overflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && quotient == 0, "R8 after reset", int'(quotient), 0);

        // Rounding on 13/7 and exact ties
        run_div(9'h0D0, 9'h070, 1'b1, "R3 13/7 even", 1'b0);
        run_div(9'h0D0, 9'h070, 1'b0, "R4 13/7 up", 1'b0);
        run_div(9'h001, 9'h020, 1'b1, "R3 tie to even zero", 1'b0);
        run_div(9'h001, 9'h020, 1'b0, "R4 tie up", 1'b0);
        run_div(9'h003, 9'h020, 1'b1, "R3 tie odd", 1'b0);
        run_div(9'h1FF, 9'h020, 1'b0, "R4 neg tie", 1'b0);
        run_div(9'h1FF, 9'h020, 1'b1, "R3 neg tie", 1'b0);
        run_div(9'h001, 9'h1E0, 1'b0, "R4 neg divisor tie", 1'b0);
        // Sign symmetry
        run_div(9'h010, 9'h1F0, 1'b1, "R5 1/-1", 1'b0);
        run_div(9'h1F0, 9'h010, 1'b1, "R5 -1/1", 1'b0);
        run_div(9'h1F0, 9'h1F0, 1'b1, "R5 -1/-1", 1'b0);
        run_div(9'h030, 9'h1E0, 1'b1, "R5 3/-2", 1'b0);
        run_div(9'h1D0, 9'h1E0, 1'b1, "R5 -3/-2", 1'b0);
        run_div(9'h078, 9'h1D8, 1'b1, "R5 7.5/-2.5", 1'b0);
        run_div(9'h188, 9'h1D8, 1'b1, "R5 -7.5/-2.5", 1'b0);
        run_div(9'h016, 9'h002, 1'b1, "R5 1.375/0.125", 1'b0);
        // Zero divisor and overflow
        run_div(9'h0D0, 9'h000, 1'b1, "R6 zero divisor", 1'b0);
        run_div(9'h100, 9'h000, 1'b0, "R6 zero divisor min", 1'b0);
        run_div(9'h100, 9'h1F0, 1'b1, "R7 -16/-1", 1'b0);
        run_div(9'h100, 9'h010, 1'b1, "R7 -16/1 fits", 1'b0);
        run_div(9'h0FF, 9'h001, 1'b1, "R7 max/lsb", 1'b0);
        run_div(9'h0FF, 9'h1FF, 1'b0, "R7 max/-lsb", 1'b0);
        // Start while busy
        run_div(9'h0D0, 9'h070, 1'b1, "R2", 1'b1);
        run_div(9'h1A3, 9'h025, 1'b0, "R2", 1'b1);

        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] rx, ry;
            logic rre;
            rx  = W'($urandom);
            ry  = W'($urandom);
            if (k % 5 == 0) ry = W'($urandom_range(0, 40));
            if (k % 7 == 0) ry = -ry;
            rre = 1'($urandom);
            run_div(rx, ry, rre, rre ? "R3 random" : "R4 random", 1'b0);
        end

        summary_and_exit();
    end
endmodule